// File: doc/BRIEF.md
# Memory Block Transfer Sequencer

This block converts one request to move a run of 32-bit words into or out of target memory into the ordered list of serial-wire debug register accesses needed to do it. A command carries a start address, a 16-bit word count and a direction. The block first points the debug port at bank 0 of the memory access port. It then loads the access port's control word with 32-bit size and single auto-increment, and loads the transfer address. After that it streams accesses to the data register, letting the target advance the address itself.

Every access goes to a separate transaction engine through a one-cycle start pulse. The engine answers with a done pulse carrying the 3-bit acknowledge and, for reads, a 32-bit value. Write words come in on a valid/ready stream. Read words leave on a valid-only stream. Access-port reads are posted: each returned value belongs to the previous access-port read. The block therefore throws away the first value and collects the final word by reading the debug port's read buffer, which does not start a new access-port access.

A WAIT acknowledge makes the block reissue the same access, up to `RETRY_MAX` times. Any other non-OK acknowledge ends the command with an error status.

Top module: `mem_block_seq`

## Requirements
- R1: While idle after reset, `cmd_ready` is 1 and `txn_start`, `wr_ready`, `rd_valid` and `done` are all 0.
- R2: A non-empty command starts with three writes in this order. First, a debug-port write to A[3:2]=2'b10 with data `{AP_INDEX, 24'h0}`, which selects access port `AP_INDEX` and bank 0. Second, an access-port write to A[3:2]=2'b00 with data `CSW_CFG` (default 32'h23000012: 32-bit size, single auto-increment). Third, an access-port write to A[3:2]=2'b01 carrying the start address.
- R3: For a write of N words, each word accepted on `wr_valid && wr_ready` becomes exactly one access-port write to A[3:2]=2'b11 with that data, in arrival order. `txn_start` follows in the cycle after acceptance, and no data write is issued before its word has arrived.
- R4: For a read of N words, the block issues N access-port reads of A[3:2]=2'b11, then one debug-port read of A[3:2]=2'b11. The first returned value is dropped. Each later returned value appears on `rd_data` with `rd_valid` in the cycle after its `txn_done`, so the words come out in address order.
- R5: A command with count 0 raises `done` with status 2'b00 in the cycle after acceptance and issues no access.
- R6: An acknowledge of 3'b010 (WAIT) makes the block reissue an identical access. After `RETRY_MAX` reissues, a further WAIT ends the command with status 2'b10.
- R7: An acknowledge of 3'b100 (FAULT) ends the command at once with status 2'b01; no further access is issued.
- R8: Any acknowledge other than 3'b001 (OK), WAIT or FAULT ends the command with status 2'b11.
- R9: `done` is a one-cycle pulse, given in the cycle after the last response. `status` is 2'b00 when every access got OK, and `cmd_ready` returns in the following cycle.
- R10: `txn_start` lasts one cycle and is not raised again until the engine has answered with `txn_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_write | input | 1 | 1 = write block, 0 = read block |
| cmd_addr | input | 32 | Start byte address |
| cmd_count | input | CNT_W | Number of 32-bit words |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Block takes the write word |
| wr_data | input | 32 | Write word |
| rd_valid | output | 1 | Read word present (one cycle) |
| rd_data | output | 32 | Read word |
| done | output | 1 | Command finished (one cycle) |
| status | output | 2 | 00 ok, 01 fault, 10 wait limit, 11 bad acknowledge |
| txn_start | output | 1 | Start one register access |
| txn_apndp | output | 1 | 1 = access port, 0 = debug port |
| txn_rnw | output | 1 | 1 = read, 0 = write |
| txn_a32 | output | 2 | Register address bits [3:2] |
| txn_wdata | output | 32 | Write value for the access |
| txn_done | input | 1 | Engine finished the access |
| txn_ack | input | 3 | Acknowledge, OK 001, WAIT 010, FAULT 100 |
| txn_rdata | input | 32 | Value returned by a read access |

## Verification
The bench models a target with posted read data and an auto-incrementing address. A design that returned the first, stale value or skipped the read-buffer fetch would deliver shifted or missing words. A design that never dropped a word would deliver one too many. Write tests stall the word stream for several cycles to catch a data access issued ahead of its word. WAIT is injected below and above the retry limit to expose an off-by-one in the retry count or a reissue with altered fields. FAULT, a malformed acknowledge and a zero count are each aimed at a design that keeps issuing accesses or misreports status after it should have stopped.

// File: rtl/mbs_pkg.sv
// Shared types and codes for the memory block sequencer.
// Assumes the debug-port acknowledge is presented as a 3-bit value,
// first received bit in bit 0.
package mbs_pkg;
    localparam int DATA_W = 32;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam logic [1:0] ST_OK     = 2'b00;
    localparam logic [1:0] ST_FAULT  = 2'b01;
    localparam logic [1:0] ST_WAITLIM = 2'b10;
    localparam logic [1:0] ST_BADACK = 2'b11;

    // Which register access the sequence is on.
    typedef enum logic [2:0] {
        STEP_SEL,
        STEP_CSW,
        STEP_TAR,
        STEP_DRW,
        STEP_RDB
    } step_e;

    // Control phase of the sequencer.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,
        PH_ISSUE,
        PH_WAIT,
        PH_FIN
    } phase_e;
endpackage

// File: rtl/mbs_word_ctr.sv
// Remaining-word counter for one block command.
// Loaded on command acceptance; decremented once per completed data access.
// Assumes no decrement is requested while the count is zero.
module mbs_word_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_last
);
    logic [CNT_W-1:0] rem_q;

    // Hold the number of data accesses still to complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec) begin
            rem_q <= rem_q - CNT_W'(1);
        end
    end

    assign is_last = (rem_q == CNT_W'(1));
endmodule

// File: rtl/mbs_retry_guard.sv
// Counts WAIT reissues of the current access and flags the limit.
// Cleared whenever an access completes with anything but a reissue.
// Assumes RETRY_MAX >= 1.
module mbs_retry_guard #(
    parameter int RETRY_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic exhausted
);
    localparam int RW = $clog2(RETRY_MAX + 1);

    logic [RW-1:0] cnt_q;

    // Track reissues made for the access in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= cnt_q + RW'(1);
        end
    end

    assign exhausted = (cnt_q == RW'(RETRY_MAX));
endmodule

// File: rtl/mbs_txn_fmt.sv
// Maps the current sequence step to the register access fields.
// Purely combinational; bank 0 of port AP_INDEX is always selected.
module mbs_txn_fmt
    import mbs_pkg::*;
#(
    parameter logic [7:0]        AP_INDEX = 8'h00,
    parameter logic [DATA_W-1:0] CSW_CFG  = 32'h2300_0012
) (
    input  step_e             step,
    input  logic              dir_wr,
    input  logic [DATA_W-1:0] start_addr,
    input  logic [DATA_W-1:0] word,
    output logic              apndp,
    output logic              rnw,
    output logic [1:0]        a32,
    output logic [DATA_W-1:0] wdata
);
    // Select port, direction, address bits and payload per step.
    always_comb begin
        apndp = 1'b0;
        rnw   = 1'b0;
        a32   = 2'b00;
        wdata = '0;
        unique case (step)
            STEP_SEL: begin
                a32   = 2'b10;
                wdata = {AP_INDEX, 24'h00_0000};
            end
            STEP_CSW: begin
                apndp = 1'b1;
                wdata = CSW_CFG;
            end
            STEP_TAR: begin
                apndp = 1'b1;
                a32   = 2'b01;
                wdata = start_addr;
            end
            STEP_DRW: begin
                apndp = 1'b1;
                rnw   = ~dir_wr;
                a32   = 2'b11;
                wdata = dir_wr ? word : '0;
            end
            STEP_RDB: begin
                rnw = 1'b1;
                a32 = 2'b11;
            end
            default: begin
                apndp = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mem_block_seq.sv
// Memory block sequencer: turns a block read or write command into the
// select / control / address / data register accesses of a memory access
// port. Assumes the engine answers each txn_start with exactly one
// txn_done pulse at least one cycle later, and that access-port reads are
// posted (value belongs to the previous access-port read).
module mem_block_seq
    import mbs_pkg::*;
#(
    parameter int                CNT_W     = 16,
    parameter int                RETRY_MAX = 8,
    parameter logic [7:0]        AP_INDEX  = 8'h00,
    parameter logic [DATA_W-1:0] CSW_CFG   = 32'h2300_0012
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [DATA_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [1:0]        status,
    output logic              txn_start,
    output logic              txn_apndp,
    output logic              txn_rnw,
    output logic [1:0]        txn_a32,
    output logic [DATA_W-1:0] txn_wdata,
    input  logic              txn_done,
    input  logic [2:0]        txn_ack,
    input  logic [DATA_W-1:0] txn_rdata
);
    phase_e            phase_q, phase_d;
    step_e             step_q, step_d;
    logic [1:0]        status_q, status_d;
    logic              dir_wr_q;
    logic              first_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wbuf_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;

    logic accept, take, rsp, ack_ok, ack_wait, ack_fault;
    logic cnt_last, cnt_dec, retry_exh, retry_bump, retry_clr, emit;

    assign cmd_ready = (phase_q == PH_IDLE);
    assign wr_ready  = (phase_q == PH_FETCH);
    assign txn_start = (phase_q == PH_ISSUE);
    assign done      = (phase_q == PH_FIN);
    assign status    = status_q;
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;

    assign accept    = cmd_valid && cmd_ready;
    assign take      = wr_valid && wr_ready;
    assign rsp       = (phase_q == PH_WAIT) && txn_done;
    assign ack_ok    = (txn_ack == ACK_OK);
    assign ack_wait  = (txn_ack == ACK_WAIT);
    assign ack_fault = (txn_ack == ACK_FAULT);

    assign cnt_dec    = rsp && ack_ok && (step_q == STEP_DRW);
    assign retry_bump = rsp && ack_wait && !retry_exh;
    assign retry_clr  = accept || (rsp && !ack_wait);
    assign emit       = rsp && ack_ok && !dir_wr_q &&
                        ((step_q == STEP_RDB) || ((step_q == STEP_DRW) && !first_q));

    mbs_word_ctr #(.CNT_W(CNT_W)) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cmd_count),
        .dec      (cnt_dec),
        .is_last  (cnt_last)
    );

    mbs_retry_guard #(.RETRY_MAX(RETRY_MAX)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (retry_clr),
        .bump      (retry_bump),
        .exhausted (retry_exh)
    );

    mbs_txn_fmt #(.AP_INDEX(AP_INDEX), .CSW_CFG(CSW_CFG)) u_fmt (
        .step       (step_q),
        .dir_wr     (dir_wr_q),
        .start_addr (addr_q),
        .word       (wbuf_q),
        .apndp      (txn_apndp),
        .rnw        (txn_rnw),
        .a32        (txn_a32),
        .wdata      (txn_wdata)
    );

    // Decide the next phase, step and final status.
    always_comb begin
        phase_d  = phase_q;
        step_d   = step_q;
        status_d = status_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    status_d = ST_OK;
                    if (cmd_count == '0) begin
                        phase_d = PH_FIN;
                    end else begin
                        step_d  = STEP_SEL;
                        phase_d = PH_ISSUE;
                    end
                end
            end
            PH_FETCH: begin
                if (take) phase_d = PH_ISSUE;
            end
            PH_ISSUE: begin
                phase_d = PH_WAIT;
            end
            PH_WAIT: begin
                if (txn_done) begin
                    if (ack_ok) begin
                        unique case (step_q)
                            STEP_SEL: begin
                                step_d  = STEP_CSW;
                                phase_d = PH_ISSUE;
                            end
                            STEP_CSW: begin
                                step_d  = STEP_TAR;
                                phase_d = PH_ISSUE;
                            end
                            STEP_TAR: begin
                                step_d  = STEP_DRW;
                                phase_d = dir_wr_q ? PH_FETCH : PH_ISSUE;
                            end
                            STEP_DRW: begin
                                if (cnt_last) begin
                                    if (dir_wr_q) begin
                                        phase_d = PH_FIN;
                                    end else begin
                                        step_d  = STEP_RDB;
                                        phase_d = PH_ISSUE;
                                    end
                                end else begin
                                    phase_d = dir_wr_q ? PH_FETCH : PH_ISSUE;
                                end
                            end
                            default: begin
                                phase_d = PH_FIN;
                            end
                        endcase
                    end else if (ack_wait && !retry_exh) begin
                        phase_d = PH_ISSUE;
                    end else begin
                        phase_d  = PH_FIN;
                        status_d = ack_wait  ? ST_WAITLIM :
                                   ack_fault ? ST_FAULT : ST_BADACK;
                    end
                end
            end
            PH_FIN: begin
                phase_d = PH_IDLE;
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    // Control state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            step_q   <= STEP_SEL;
            status_q <= ST_OK;
        end else begin
            phase_q  <= phase_d;
            step_q   <= step_d;
            status_q <= status_d;
        end
    end

    // Capture command fields, the pending write word and the posted-read flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_wr_q <= 1'b0;
            addr_q   <= '0;
            wbuf_q   <= '0;
            first_q  <= 1'b0;
        end else begin
            if (accept) begin
                dir_wr_q <= cmd_write;
                addr_q   <= cmd_addr;
                first_q  <= 1'b1;
            end else if (cnt_dec) begin
                first_q  <= 1'b0;
            end
            if (take) wbuf_q <= wr_data;
        end
    end

    // Register read words leaving the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= emit;
            if (emit) rd_data_q <= txn_rdata;
        end
    end
endmodule

// File: rtl/mem_block_seq_chk.sv
// Protocol checker for mem_block_seq, attached by bind.
// Tracks the outstanding access and pending reissue on its own.
module mem_block_seq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [CNT_W-1:0] cmd_count,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             done,
    input logic [1:0]       status,
    input logic             txn_start,
    input logic             txn_apndp,
    input logic             txn_rnw,
    input logic [1:0]       txn_a32,
    input logic [31:0]      txn_wdata,
    input logic             txn_done,
    input logic [2:0]       txn_ack
);
    logic        outst_q;
    logic        repend_q;
    logic [35:0] saved_q;
    logic [35:0] fields;

    assign fields = {txn_apndp, txn_rnw, txn_a32, txn_wdata};

    // Follow the access in flight and whether the next start is a reissue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q  <= 1'b0;
            repend_q <= 1'b0;
            saved_q  <= '0;
        end else begin
            if (txn_start) begin
                outst_q <= 1'b1;
                saved_q <= fields;
            end else if (txn_done) begin
                outst_q <= 1'b0;
            end
            if (done) repend_q <= 1'b0;
            else if (txn_done && outst_q) repend_q <= (txn_ack == 3'b010);
            else if (txn_start) repend_q <= 1'b0;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!txn_start && !wr_ready && !done));

    // R3
    word_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> txn_start);

    // R5
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_count == '0) |=> (done && status == 2'b00 && !txn_start));

    // R6
    retry_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && repend_q) |-> (fields == saved_q));

    // R7
    fault_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outst_q && txn_done && txn_ack == 3'b100) |=> (done && status == 2'b01));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

    // R10
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> !txn_start);

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !txn_start);
endmodule

bind mem_block_seq mem_block_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_count (cmd_count),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .done      (done),
    .status    (status),
    .txn_start (txn_start),
    .txn_apndp (txn_apndp),
    .txn_rnw   (txn_rnw),
    .txn_a32   (txn_a32),
    .txn_wdata (txn_wdata),
    .txn_done  (txn_done),
    .txn_ack   (txn_ack)
);

// File: tb/mem_block_seq_tb.sv
// Bench: behavioural target (posted reads, auto-increment address, write log)
// plus queues of expected accesses and read words, compared every clock.
module mem_block_seq_tb;
    localparam int RETRIES = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_count = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_data = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        done;
    logic [1:0]  status;
    logic        txn_start;
    logic        txn_apndp;
    logic        txn_rnw;
    logic [1:0]  txn_a32;
    logic [31:0] txn_wdata;
    logic        txn_done = 1'b0;
    logic [2:0]  txn_ack = 3'b000;
    logic [31:0] txn_rdata = '0;

    always #5 clk = ~clk;

    mem_block_seq #(.CNT_W(16), .RETRY_MAX(RETRIES)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_count(cmd_count),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .status(status),
        .txn_start(txn_start), .txn_apndp(txn_apndp), .txn_rnw(txn_rnw),
        .txn_a32(txn_a32), .txn_wdata(txn_wdata),
        .txn_done(txn_done), .txn_ack(txn_ack), .txn_rdata(txn_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [35:0] exp_txn[$];
    logic [31:0] exp_rd[$];
    logic [63:0] exp_wlog[$];
    logic [63:0] wlog[$];
    logic [31:0] wsrc[$];

    // target model state
    logic [31:0] tar = '0;
    logic [31:0] posted = '0;
    bit          busy = 0;
    int          cd = 0;
    int          lat = 0;
    int          txn_total = 0;
    int          uniq = 0;
    bit          last_wait = 0;
    logic [35:0] last_fields = '0;
    int          wait_at = -1;
    int          wait_left = 0;
    int          fault_at = -1;
    int          bad_at = -1;
    int          resp_cyc = -10;
    int          gap = 0;
    bit          done_seen = 0;
    logic [1:0]  done_status = '0;
    int          done_cyc = -10;

    function automatic logic [31:0] memval(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[31:16] + 16'h0101};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_sim();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_sim();
    end

    // target engine: answers each start, models posted reads and auto-increment
    initial forever begin
        @(negedge clk);
        txn_done = 1'b0;
        if (busy) begin
            check(!txn_start, "R10 start while outstanding", txn_start, 0);
            if (cd > 0) begin
                cd--;
            end else begin
                logic [2:0]  a;
                logic [31:0] rv;
                rv = 32'hDEAD_BEEF;
                if (uniq == fault_at) a = 3'b100;
                else if (uniq == bad_at) a = 3'b111;
                else if (uniq == wait_at && wait_left > 0) begin
                    a = 3'b010;
                    wait_left--;
                end else a = 3'b001;
                if (a == 3'b001) begin
                    if (last_fields[35] && !last_fields[34] && last_fields[33:32] == 2'b01)
                        tar = last_fields[31:0];
                    else if (last_fields[35] && last_fields[33:32] == 2'b11) begin
                        if (last_fields[34]) begin
                            rv = posted;
                            posted = memval(tar);
                        end else begin
                            wlog.push_back({tar, last_fields[31:0]});
                        end
                        tar = tar + 32'd4;
                    end else if (!last_fields[35] && last_fields[34] && last_fields[33:32] == 2'b11)
                        rv = posted;
                end
                txn_done  = 1'b1;
                txn_ack   = a;
                txn_rdata = rv;
                resp_cyc  = cyc;
                last_wait = (a == 3'b010);
                if (!last_wait) uniq++;
                busy = 0;
            end
        end else if (txn_start) begin
            logic [35:0] f;
            f = {txn_apndp, txn_rnw, txn_a32, txn_wdata};
            txn_total++;
            if (last_wait) begin
                // R6: reissue must be identical
                check(f == last_fields, "R6 reissue fields", f, last_fields);
            end else if (exp_txn.size() == 0) begin
                check(0, "R2 unexpected access", f, 0);
            end else begin
                logic [35:0] e;
                logic [35:0] m;
                e = exp_txn.pop_front();
                m = e[34] ? 36'hF_0000_0000 : 36'hF_FFFF_FFFF;
                check((f & m) == (e & m),
                      (e[35] && e[33:32] == 2'b11) ? (e[34] ? "R4 data read" : "R3 data write") :
                      (e[33:32] == 2'b11 ? "R4 read buffer" : "R2 prologue"),
                      f & m, e & m);
            end
            last_fields = f;
            busy = 1;
            cd = lat;
        end
    end

    // write word source with optional gaps between words
    initial begin
        bit hs_prev;
        int gcnt;
        hs_prev = 0;
        gcnt = 0;
        forever begin
            @(negedge clk);
            if (hs_prev) begin
                void'(wsrc.pop_front());
                gcnt = gap;
            end
            if (wsrc.size() > 0 && gcnt == 0) begin
                wr_valid = 1'b1;
                wr_data  = wsrc[0];
            end else begin
                wr_valid = 1'b0;
                if (gcnt > 0) gcnt--;
            end
            hs_prev = wr_valid && wr_ready;
        end
    end

    // output monitor: read words and done pulses
    initial forever begin
        @(negedge clk);
        if (rd_valid) begin
            check(resp_cyc == cyc - 1, "R4 read word timing", cyc - resp_cyc, 1);
            if (exp_rd.size() == 0) check(0, "R4 extra read word", rd_data, 0);
            else begin
                logic [31:0] e;
                e = exp_rd.pop_front();
                check(rd_data == e, "R4 read word value", rd_data, e);
            end
        end
        if (done) begin
            check(done_cyc != cyc - 1, "R9 done pulse width", 1, 0);
            done_seen   = 1;
            done_status = status;
            done_cyc    = cyc;
        end
    end

    task automatic plan(input bit wr, input logic [31:0] a, input int n);
        exp_txn.push_back({1'b0, 1'b0, 2'b10, 32'h0000_0000});
        exp_txn.push_back({1'b1, 1'b0, 2'b00, 32'h2300_0012});
        exp_txn.push_back({1'b1, 1'b0, 2'b01, a});
        for (int i = 0; i < n; i++) begin
            if (wr) begin
                logic [31:0] w;
                w = 32'h1000_0000 + a + 32'(i * 7);
                wsrc.push_back(w);
                exp_txn.push_back({1'b1, 1'b0, 2'b11, w});
                exp_wlog.push_back({a + 32'(4 * i), w});
            end else begin
                exp_txn.push_back({1'b1, 1'b1, 2'b11, 32'h0});
                exp_rd.push_back(memval(a + 32'(4 * i)));
            end
        end
        if (!wr && n > 0) exp_txn.push_back({1'b0, 1'b1, 2'b11, 32'h0});
    endtask

    task automatic run_cmd(input bit wr, input logic [31:0] a, input logic [15:0] n);
        @(negedge clk);
        check(cmd_ready, "R9 ready before command", cmd_ready, 1);
        done_seen = 0;
        wlog.delete();
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = a;
        cmd_count = n;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag, input logic [1:0] exp_st);
        int k;
        k = 0;
        while (!done_seen && k < 3000) begin
            @(negedge clk);
            k++;
        end
        check(done_seen, {tag, " done seen"}, done_seen, 1);
        check(done_status == exp_st, {tag, " status"}, done_status, exp_st);
        @(negedge clk);
        check(cmd_ready, "R9 ready after done", cmd_ready, 1);
    endtask

    task automatic clean();
        exp_txn.delete();
        exp_rd.delete();
        exp_wlog.delete();
        wsrc.delete();
        wait_at = -1;
        wait_left = 0;
        fault_at = -1;
        bad_at = -1;
        last_wait = 0;
        uniq = 0;
        gap = 0;
        lat = 0;
    endtask

    task automatic check_writes(input string tag);
        check(wlog.size() == exp_wlog.size(), {tag, " write count"}, wlog.size(), exp_wlog.size());
        for (int i = 0; i < exp_wlog.size() && i < wlog.size(); i++)
            check(wlog[i] == exp_wlog[i], {tag, " write addr/data"}, wlog[i], exp_wlog[i]);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cmd_ready && !txn_start && !wr_ready && !rd_valid && !done, "R1 idle outputs",
              {cmd_ready, txn_start, wr_ready, rd_valid, done}, 5'b10000);

        // R2 R3: write 4 words, no gaps
        clean();
        plan(1, 32'h2000_0000, 4);
        run_cmd(1, 32'h2000_0000, 4);
        wait_done("R3 write4", 2'b00);
        check(exp_txn.size() == 0, "R3 all accesses issued", exp_txn.size(), 0);
        check_writes("R3");

        // R4: read 5 words, slow engine
        clean();
        lat = 2;
        plan(0, 32'h2000_0040, 5);
        run_cmd(0, 32'h2000_0040, 5);
        wait_done("R4 read5", 2'b00);
        check(exp_txn.size() == 0, "R4 read accesses issued", exp_txn.size(), 0);
        check(exp_rd.size() == 0, "R4 read words delivered", exp_rd.size(), 0);

        // R4: single-word read
        clean();
        plan(0, 32'h2000_1000, 1);
        run_cmd(0, 32'h2000_1000, 1);
        wait_done("R4 read1", 2'b00);
        check(exp_txn.size() == 0 && exp_rd.size() == 0, "R4 read1 complete",
              exp_txn.size() + exp_rd.size(), 0);

        // R5: zero count
        clean();
        base = txn_total;
        run_cmd(1, 32'h2000_2000, 0);
        check(done, "R5 done next cycle", done, 1);
        wait_done("R5 zero", 2'b00);
        check(txn_total == base, "R5 no access", txn_total - base, 0);

        // R3: write 3 words with a starved stream
        clean();
        gap = 4;
        lat = 1;
        plan(1, 32'h2000_0200, 3);
        run_cmd(1, 32'h2000_0200, 3);
        wait_done("R3 gapped write", 2'b00);
        check(exp_txn.size() == 0, "R3 gapped accesses", exp_txn.size(), 0);
        check_writes("R3 gapped");

        // R6: two WAITs on first data write, within the limit
        clean();
        base = txn_total;
        wait_at = 3;
        wait_left = 2;
        plan(1, 32'h2000_0300, 2);
        run_cmd(1, 32'h2000_0300, 2);
        wait_done("R6 wait retry", 2'b00);
        check(txn_total - base == 7, "R6 access count with reissues", txn_total - base, 7);
        check_writes("R6");

        // R6: WAIT beyond the limit on the control-word write
        clean();
        base = txn_total;
        wait_at = 1;
        wait_left = 3;
        plan(0, 32'h2000_0400, 2);
        run_cmd(0, 32'h2000_0400, 2);
        wait_done("R6 wait limit", 2'b10);
        check(txn_total - base == 1 + 1 + RETRIES, "R6 accesses before giving up",
              txn_total - base, 1 + 1 + RETRIES);

        // R7: FAULT on the address write
        clean();
        base = txn_total;
        fault_at = 2;
        plan(0, 32'h2000_0500, 3);
        run_cmd(0, 32'h2000_0500, 3);
        wait_done("R7 fault", 2'b01);
        repeat (4) @(negedge clk);
        check(txn_total - base == 3, "R7 no access after fault", txn_total - base, 3);

        // R8: malformed acknowledge on the select write
        clean();
        base = txn_total;
        bad_at = 0;
        plan(0, 32'h2000_0600, 2);
        run_cmd(0, 32'h2000_0600, 2);
        wait_done("R8 bad ack", 2'b11);
        check(txn_total - base == 1, "R8 single access", txn_total - base, 1);

        // R4: clean read after error recovery
        clean();
        plan(0, 32'h2000_0080, 3);
        run_cmd(0, 32'h2000_0080, 3);
        wait_done("R4 read after errors", 2'b00);
        check(exp_txn.size() == 0 && exp_rd.size() == 0, "R4 read3 complete",
              exp_txn.size() + exp_rd.size(), 0);

        repeat (5) @(negedge clk);
        finish_sim();
    end
endmodule